// File: doc/BRIEF.md
# Reservation Unit for Atomic Load-Reserve / Store-Conditional

This block sits between a simple core pipeline and a word-addressed memory port. It lets software build atomic read-modify-write sequences such as test-and-set, compare-and-swap and fetch-and-add. The core sends it two kinds of request. A load-reserve reads a word and marks that word as reserved. A store-conditional writes a word only if the reservation is still held, and reports the outcome through an equal-condition flag.

Each request carries a base operand, an index operand, a flag saying whether the base register field is zero, and store data. The block forms the effective address, keeps a single reservation, and performs the memory access over a request/acknowledge port. It returns load data or the condition flag with a one-cycle response pulse. A snoop port reports stores made by other agents. A snooped store that hits the reserved word cancels the reservation.

Top module: `rsv_unit`

## Requirements
- R1: The effective address is index plus base. When the base-zero flag is 1, a constant zero is used in place of the base operand.
- R2: A load-reserve (req_op = 0) reads the word at the effective address and returns it on rsp_data with rsp_eq = 0. The same request records a valid reservation for that word.
- R3: A store-conditional (req_op = 1) that finds a valid reservation for its own word writes req_src to that word once, and then responds with rsp_eq = 1 and rsp_data = 0.
- R4: A store-conditional that finds no valid reservation for its word issues no memory write, so the addressed word keeps its value.
- R5: A failing store-conditional responds with rsp_eq = 0 and rsp_data = 0.
- R6: Every store-conditional, whether it succeeds or fails, leaves no reservation behind. A second store-conditional fails.
- R7: Only one reservation exists. A new load-reserve moves it to the new word, and a store-conditional to the old word then fails.
- R8: A snooped store (snp_valid = 1) whose word matches the reservation clears it. A snooped store to any other word leaves it in place.
- R9: A snooped store to the reserved word, in the same cycle as a store-conditional is accepted, makes that store-conditional fail.
- R10: Addresses are compared by word. Byte address bits [1:0] are ignored for the reservation, the snoop match and mem_addr.
- R11: After reset, req_ready = 1, rsp_valid = 0, mem_req = 0 and no reservation is held, so the first store-conditional fails.
- R12: A request is accepted when req_valid and req_ready are both 1. req_ready stays 0 while a memory access is pending. mem_req holds its address, data and write enable steady until mem_ack. Each accepted request gets exactly one one-cycle rsp_valid pulse, which follows mem_ack or, for a failing store-conditional, follows acceptance.
- R13: A snooped store to the same word, in the same cycle as a load-reserve is accepted, does not cancel the new reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 1 | 0 = load-reserve, 1 = store-conditional |
| req_base_zero | input | 1 | Base register field is zero; use 0 as base |
| req_base | input | ADDR_W | Base operand |
| req_index | input | ADDR_W | Index operand |
| req_src | input | DATA_W | Store data for store-conditional |
| snp_valid | input | 1 | Another agent stores this cycle |
| snp_addr | input | ADDR_W | Byte address of the snooped store |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Memory completes the access |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | DATA_W | Load data (0 for store-conditional) |
| rsp_eq | output | 1 | Store-conditional success flag |

## Verification
A snooped store can land in the same cycle that a request is accepted. Against a store-conditional it must cause a failure. Against a load-reserve the new reservation must survive. The bench drives snp_valid together with req_valid in one cycle, for the same word and also for different words. A behavioural reservation model settles each case: a load-reserve wins, while a store-conditional sees the snooped store first. The bench then judges the outcome from the rsp_eq value and from whether a memory write appears.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic {
    OP_LOAD_RSV  = 1'b0,
    OP_STORE_CND = 1'b1
  } rsv_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_MEM  = 1'b1
  } rsv_state_e;
endpackage

// File: rtl/rsv_ea.sv
module rsv_ea #(
  parameter int ADDR_W = 32,
  localparam int WORD_W = ADDR_W - 2
) (
  input  logic              base_zero,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index,
  output logic [WORD_W-1:0] word
);
  logic [ADDR_W-1:0] base_term;
  logic [ADDR_W-1:0] ea;

  assign base_term = base_zero ? '0 : base;
  assign ea        = base_term + index;
  assign word      = ea[ADDR_W-1:2];
endmodule

// File: rtl/rsv_track.sv
module rsv_track #(
  parameter int WORD_W = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set,
  input  logic              clr,
  input  logic [WORD_W-1:0] set_word,
  input  logic              snp_valid,
  input  logic [WORD_W-1:0] snp_word,
  input  logic [WORD_W-1:0] query_word,
  output logic              rsv_valid,
  output logic [WORD_W-1:0] rsv_word,
  output logic              hit
);
  logic snp_hit;

  // another agent's store to the held word cancels it, even this cycle
  assign snp_hit = snp_valid && rsv_valid && (snp_word == rsv_word);
  assign hit     = rsv_valid && (rsv_word == query_word) && !snp_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsv_valid <= 1'b0;
      rsv_word  <= '0;
    end else if (set) begin
      rsv_valid <= 1'b1;
      rsv_word  <= set_word;
    end else if (clr || snp_hit) begin
      rsv_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rsv_ctrl.sv
module rsv_ctrl
  import rsv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WORD_W = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_op,
  input  logic [WORD_W-1:0] word,
  input  logic [DATA_W-1:0] src,
  input  logic              sc_hit,
  output logic              req_ready,
  output logic              lr_go,
  output logic              sc_go,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_eq
);
  rsv_state_e state;
  logic       accept;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign lr_go     = accept && (rsv_op_e'(req_op) == OP_LOAD_RSV);
  assign sc_go     = accept && (rsv_op_e'(req_op) == OP_STORE_CND);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_eq    <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (lr_go || (sc_go && sc_hit)) begin
            state     <= ST_MEM;
            mem_req   <= 1'b1;
            mem_we    <= sc_go;
            mem_addr  <= word;
            mem_wdata <= src;
          end else if (sc_go) begin
            rsp_valid <= 1'b1;
            rsp_data  <= '0;
            rsp_eq    <= 1'b0;
          end
        end
        ST_MEM: begin
          if (mem_ack) begin
            state     <= ST_IDLE;
            mem_req   <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_data  <= mem_we ? '0 : mem_rdata;
            rsp_eq    <= mem_we;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rsv_unit.sv
module rsv_unit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int WORD_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic              req_base_zero,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [ADDR_W-1:0] req_index,
  input  logic [DATA_W-1:0] req_src,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_eq
);
  logic [WORD_W-1:0] ea_word;
  logic [WORD_W-1:0] rsv_word;
  logic              rsv_valid;
  logic              sc_hit;
  logic              lr_go;
  logic              sc_go;

  rsv_ea #(.ADDR_W(ADDR_W)) u_ea (
    .base_zero (req_base_zero),
    .base      (req_base),
    .index     (req_index),
    .word      (ea_word)
  );

  rsv_track #(.WORD_W(WORD_W)) u_track (
    .clk        (clk),
    .rst        (rst),
    .set        (lr_go),
    .clr        (sc_go),
    .set_word   (ea_word),
    .snp_valid  (snp_valid),
    .snp_word   (snp_addr[ADDR_W-1:2]),
    .query_word (ea_word),
    .rsv_valid  (rsv_valid),
    .rsv_word   (rsv_word),
    .hit        (sc_hit)
  );

  rsv_ctrl #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .word      (ea_word),
    .src       (req_src),
    .sc_hit    (sc_hit),
    .req_ready (req_ready),
    .lr_go     (lr_go),
    .sc_go     (sc_go),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_eq    (rsp_eq)
  );
endmodule

// File: rtl/rsv_unit_chk.sv
module rsv_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int WORD_W = ADDR_W - 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              snp_valid,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              mem_req,
  input logic              mem_we,
  input logic [WORD_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              rsp_valid,
  input logic [WORD_W-1:0] ea_word,
  input logic              rsv_valid,
  input logic [WORD_W-1:0] rsv_word,
  input logic              sc_hit,
  input logic              lr_go,
  input logic              sc_go
);
  p_lr_sets_r2: assert property (@(posedge clk) disable iff (rst)
    lr_go |=> rsv_valid && (rsv_word == $past(ea_word)));

  p_fail_nowrite_r4: assert property (@(posedge clk) disable iff (rst)
    (sc_go && !sc_hit) |=> !mem_req);

  p_sc_clears_r6: assert property (@(posedge clk) disable iff (rst)
    sc_go |=> !rsv_valid);

  p_snoop_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && rsv_valid && (snp_addr[ADDR_W-1:2] == rsv_word) && !lr_go) |=> !rsv_valid);

  p_reset_state_r11: assert property (@(posedge clk)
    rst |=> !rsv_valid && !rsp_valid && !mem_req);

  p_busy_r12: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);

  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_rsp_idle_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !mem_req);
endmodule

bind rsv_unit rsv_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .snp_valid (snp_valid),
  .snp_addr  (snp_addr),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .rsp_valid (rsp_valid),
  .ea_word   (ea_word),
  .rsv_valid (rsv_valid),
  .rsv_word  (rsv_word),
  .sc_hit    (sc_hit),
  .lr_go     (lr_go),
  .sc_go     (sc_go)
);

// File: tb/sim_rsv_unit.sv
`timescale 1ns/1ps
module sim_rsv_unit;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int WW = AW - 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_op = 1'b0;
  logic          req_base_zero = 1'b0;
  logic [AW-1:0] req_base = '0;
  logic [AW-1:0] req_index = '0;
  logic [DW-1:0] req_src = '0;
  logic          snp_valid = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic          mem_req;
  logic          mem_we;
  logic [WW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          rsp_eq;

  always #2 clk = ~clk;

  rsv_unit #(.ADDR_W(AW), .DATA_W(DW)) u0 (.*);

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  // behavioural reference state
  logic [DW-1:0] bmem [logic [WW-1:0]];
  bit            m_rv = 0;
  logic [WW-1:0] m_ra = '0;
  logic          e_eq [$];
  logic [DW-1:0] e_dat [$];
  string         e_tag [$];
  logic [WW-1:0] w_addr [$];
  logic [DW-1:0] w_dat [$];
  int            lat_sel = 0;
  int            lat_cnt = 0;

  function automatic logic [DW-1:0] rd(logic [WW-1:0] w);
    if (bmem.exists(w)) return bmem[w];
    return {w[15:0], 16'h5A3C} ^ 32'h0F0F_0000;
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder: variable latency, write checked against the model
  always @(negedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      lat_cnt = 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (lat_cnt == 0) begin
        if (mem_we) begin
          if (w_addr.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R4 unexpected write addr=%h data=%h expected=none", mem_addr, mem_wdata);
          end else begin
            check("R3 write addr", {2'b00, mem_addr}, {2'b00, w_addr.pop_front()});
            check("R3 write data", mem_wdata, w_dat.pop_front());
          end
          bmem[mem_addr] = mem_wdata;
        end else begin
          mem_rdata <= rd(mem_addr);
        end
        mem_ack <= 1'b1;
        lat_sel++;
        lat_cnt = lat_sel % 3;
      end else begin
        lat_cnt--;
      end
    end
  end

  // response monitor, every clock
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (e_eq.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R12 response with none pending actual=1 expected=0");
      end else begin
        string t;
        t = e_tag.pop_front();
        check({t, " eq"}, {31'b0, rsp_eq}, {31'b0, e_eq.pop_front()});
        check({t, " data"}, rsp_data, e_dat.pop_front());
      end
    end
  end

  // one request, optionally with a snoop in the same cycle
  task automatic issue(string tag, bit op, bit bz, logic [AW-1:0] base, logic [AW-1:0] idx,
                       logic [DW-1:0] src, bit snp, logic [AW-1:0] saddr);
    logic [AW-1:0] ea;
    logic [WW-1:0] w;
    bit            hit;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_op = op; req_base_zero = bz; req_base = base;
    req_index = idx; req_src = src; snp_valid = snp; snp_addr = saddr;
    ea = (bz ? '0 : base) + idx;
    w  = ea[AW-1:2];
    if (!op) begin
      m_rv = 1; m_ra = w;
      e_eq.push_back(1'b0); e_dat.push_back(rd(w)); e_tag.push_back(tag);
    end else begin
      hit = m_rv && (m_ra == w) && !(snp && (saddr[AW-1:2] == m_ra));
      m_rv = 0;
      e_eq.push_back(hit); e_dat.push_back('0); e_tag.push_back(tag);
      if (hit) begin w_addr.push_back(w); w_dat.push_back(src); end
    end
    @(negedge clk);
    req_valid = 0; snp_valid = 0;
  endtask

  task automatic snoop(logic [AW-1:0] saddr);
    @(negedge clk);
    snp_valid = 1; snp_addr = saddr;
    if (m_rv && (m_ra == saddr[AW-1:2])) m_rv = 0;
    @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic drain;
    while (e_eq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11: reset state
    check("R11 ready", {31'b0, req_ready}, 32'd1);
    check("R11 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R11 mem_req", {31'b0, mem_req}, 32'd0);
    issue("R11 first SC fails", 1, 1, 32'h0, 32'h100, 32'hAAAA_0001, 0, 0);
    // R1 base forced to zero, R2 load data
    issue("R1 R2 LR bz", 0, 1, 32'hDEAD_0000, 32'h100, 0, 0, 0);
    issue("R3 R5 SC ok", 1, 1, 32'h1234_0000, 32'h100, 32'h1111_1111, 0, 0);
    issue("R6 second SC fails", 1, 1, 32'h0, 32'h100, 32'h2222_2222, 0, 0);
    issue("R2 readback", 0, 1, 32'h0, 32'h100, 0, 0, 0);
    // R1 base + index
    issue("R1 LR base+idx", 0, 0, 32'h200, 32'h4, 0, 0, 0);
    issue("R1 SC base+idx", 1, 1, 32'h0, 32'h204, 32'h3333_3333, 0, 0);
    // R7 replacement
    issue("R7 LR old", 0, 1, 32'h0, 32'h300, 0, 0, 0);
    issue("R7 LR new", 0, 1, 32'h0, 32'h400, 0, 0, 0);
    issue("R7 SC old fails", 1, 1, 32'h0, 32'h300, 32'h4444_4444, 0, 0);
    issue("R4 old word intact", 0, 1, 32'h0, 32'h300, 0, 0, 0);
    // R8 R10 snoop with differing low bits
    issue("R8 LR", 0, 1, 32'h0, 32'h500, 0, 0, 0);
    snoop(32'h502);
    issue("R8 R10 SC after snoop fails", 1, 1, 32'h0, 32'h500, 32'h5555_5555, 0, 0);
    // R8 snoop elsewhere keeps it
    issue("R8 LR", 0, 1, 32'h0, 32'h900, 0, 0, 0);
    snoop(32'h904);
    issue("R8 SC other-word snoop ok", 1, 1, 32'h0, 32'h900, 32'h9999_9999, 0, 0);
    // R10 byte offset in store address
    issue("R10 LR", 0, 1, 32'h0, 32'h600, 0, 0, 0);
    issue("R10 SC offset ok", 1, 0, 32'h600, 32'h3, 32'h6666_6666, 0, 0);
    // R9 same-cycle snoop with SC
    issue("R9 LR", 0, 1, 32'h0, 32'h700, 0, 0, 0);
    issue("R9 SC with snoop fails", 1, 1, 32'h0, 32'h700, 32'h7777_7777, 1, 32'h701);
    issue("R4 R9 word intact", 0, 1, 32'h0, 32'h700, 0, 0, 0);
    // same-cycle snoop, other word: SC still succeeds
    issue("R9 SC other snoop ok", 1, 1, 32'h0, 32'h700, 32'h7878_7878, 1, 32'h780);
    // R13 same-cycle snoop with LR
    issue("R13 LR with snoop", 0, 1, 32'h0, 32'h800, 0, 1, 32'h800);
    issue("R13 SC ok", 1, 1, 32'h0, 32'h800, 32'h8888_8888, 0, 0);
    // R4 SC to unreserved word
    issue("R4 LR", 0, 1, 32'h0, 32'hA00, 0, 0, 0);
    issue("R4 SC wrong word", 1, 0, 32'hA00, 32'h10, 32'hBBBB_BBBB, 0, 0);
    issue("R4 wrong word intact", 0, 1, 32'h0, 32'hA10, 0, 0, 0);
    // R12 back-to-back fails and final ready
    issue("R12 SC fail a", 1, 1, 32'h0, 32'hB00, 0, 0, 0);
    issue("R12 SC fail b", 1, 1, 32'h0, 32'hB04, 0, 0, 0);
    drain();
    check("R12 ready after drain", {31'b0, req_ready}, 32'd1);
    check("R4 no stray writes pending", w_addr.size(), 32'd0);
    finish_run();
  end
endmodule